// File: doc/BRIEF.md
# Byte-Mask Selected Flow Tag Generator

This block derives a 32-bit flow tag for each packet from a chosen subset of its first 128 bytes. Four independent byte masks are kept in a small bank of 8-bit registers. A packet picks one of them with a mask index at start-of-packet. As the packet streams in, one byte per valid beat, every byte whose mask bit is set is folded into a CRC-32 accumulator. The tag appears on `tag_out` together with a one-cycle `tag_valid` strobe. The strobe follows the end-of-packet beat, or the beat carrying byte offset 127 if the packet runs longer than that.

A packet can turn masking off through its tag-enable input. It also supplies a fallback tag. This fallback is emitted whenever masking is off or no byte of the packet was selected. Mask registers can be written at any time. Each packet captures its mask when it starts, so a write made while a packet is in flight only changes the packets that start after it.

Top module: `bytemask_tag_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tag_valid` is 0 and `tag_out` is 0.
- R2: Mask m is held in register indices m*16 to m*16+15. Packet byte offset X of mask m is enabled by register m*16 + X/8, bit 7 - (X mod 8), so the lowest offset of each register sits in bit 7. A register write replaces all 8 bits.
- R3: The enabled bytes are folded in offset order into a CRC-32 with polynomial 0x04C11DB7 and start value 0xFFFFFFFF. Each byte is taken most significant bit first, with no reflection and no final inversion. The resulting register value is the tag. For bytes "123456789" this gives 0x0376E6E7.
- R4: A packet that ends at or before offset 127 raises `tag_valid` for one cycle. This happens in the cycle after its end-of-packet beat. A packet of one beat, with start and end together, is legal.
- R5: A packet longer than 128 bytes is tagged one cycle after the beat carrying offset 127. Its later bytes and its end-of-packet beat produce no further strobe.
- R6: If tag enable was 0 at the start beat, the tag equals the default tag sampled at that beat.
- R7: If tag enable was 1 but no byte of the packet had its mask bit set, the tag equals the sampled default tag.
- R8: A mask write in the start beat's cycle or later within a packet does not affect that packet. It applies from the next start-of-packet.
- R9: `in_mask_sel` chooses one of four independent masks. Writes to one mask do not change the tags produced with another.
- R10: `tag_out` changes only in cycles where `tag_valid` is 1.
- R11: Cycles with `in_valid` low do not advance the byte offset and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Mask register write enable |
| cfg_addr | input | 6 | Mask register index (mask*16 + offset/8) |
| cfg_data | input | 8 | Mask register write value |
| in_valid | input | 1 | Packet byte present |
| in_sop | input | 1 | Byte is offset 0 of a new packet |
| in_eop | input | 1 | Byte is the last of its packet |
| in_data | input | 8 | Packet byte |
| in_mask_sel | input | 2 | Mask index, sampled with the start beat |
| in_tag_en | input | 1 | Masked tagging enable, sampled with the start beat |
| in_default_tag | input | 32 | Fallback tag, sampled with the start beat |
| tag_valid | output | 1 | One-cycle strobe: `tag_out` holds a new tag |
| tag_out | output | 32 | Flow tag of the last finished packet |

## Verification
The assertions assume well-framed input. Every packet opens with a start beat, and an end beat never arrives outside a packet. The per-packet fields are meaningful only on the start beat. The stimulus only builds whole packets through one task that raises start on the first beat and end on the last. Idle cycles and mask writes are inserted between beats, including on the start beat itself. No stray end-of-packet beat is ever driven.

// File: rtl/btg_pkg.sv
package btg_pkg;

    localparam int          TAG_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    // Per-packet settings latched with the start beat
    typedef struct packed {
        logic             tag_en;
        logic [TAG_W-1:0] dflt;
    } pkt_cfg_t;

    // One byte into a left-shifting CRC-32, bit 7 first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/btg_mask_bank.sv
module btg_mask_bank #(
    parameter int NUM_MASKS  = 4,
    parameter int MASK_BYTES = 128,
    localparam int REGS      = MASK_BYTES / 8,
    localparam int NREG      = NUM_MASKS * REGS,
    localparam int AW        = $clog2(NREG),
    localparam int SW        = $clog2(NUM_MASKS),
    localparam int RW        = $clog2(REGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [SW-1:0]         rd_sel,
    input  logic                  snap_en,
    output logic [MASK_BYTES-1:0] live_mask,
    output logic [MASK_BYTES-1:0] held_mask
);

    logic [7:0] regs     [NREG];
    logic [7:0] sel_regs [REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        for (int r = 0; r < REGS; r++) sel_regs[r] = regs[{rd_sel, RW'(r)}];
    end

    // Offset x lives in register x/8, lowest offset in bit 7
    for (genvar gx = 0; gx < MASK_BYTES; gx++) begin : g_bit
        assign live_mask[gx] = sel_regs[gx / 8][7 - (gx % 8)];
    end

    always_ff @(posedge clk) begin
        if (rst)          held_mask <= '0;
        else if (snap_en) held_mask <= live_mask;
    end

endmodule

// File: rtl/btg_crc_fold.sv
module btg_crc_fold
    import btg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        beat,
    input  logic        start,
    input  logic        take,
    input  logic [7:0]  data,
    output logic [31:0] crc_nxt,
    output logic        hit_nxt
);

    logic [31:0] crc_q;
    logic        hit_q;
    logic [31:0] base;

    always_comb begin
        base    = start ? CRC_SEED : crc_q;
        crc_nxt = take ? crc32_byte(base, data) : base;
        hit_nxt = (start ? 1'b0 : hit_q) | take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
            hit_q <= 1'b0;
        end else if (beat) begin
            crc_q <= crc_nxt;
            hit_q <= hit_nxt;
        end
    end

endmodule

// File: rtl/bytemask_tag_gen.sv
module bytemask_tag_gen
    import btg_pkg::*;
#(
    parameter int NUM_MASKS  = 4,
    parameter int MASK_BYTES = 128,
    localparam int REGS      = MASK_BYTES / 8,
    localparam int AW        = $clog2(NUM_MASKS * REGS),
    localparam int SW        = $clog2(NUM_MASKS),
    localparam int OW        = $clog2(MASK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [7:0]       cfg_data,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    input  logic [SW-1:0]    in_mask_sel,
    input  logic             in_tag_en,
    input  logic [TAG_W-1:0] in_default_tag,
    output logic             tag_valid,
    output logic [TAG_W-1:0] tag_out
);

    logic                  busy_q;
    logic [OW-1:0]         off_q;
    pkt_cfg_t              cfg_q;
    pkt_cfg_t              cur_cfg;
    logic [OW-1:0]         cur_off;
    logic [MASK_BYTES-1:0] live_mask;
    logic [MASK_BYTES-1:0] held_mask;
    logic                  beat, sel_bit, take, last;
    logic [31:0]           crc_nxt;
    logic                  hit_nxt;

    btg_mask_bank #(.NUM_MASKS(NUM_MASKS), .MASK_BYTES(MASK_BYTES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_data),
        .rd_sel    (in_mask_sel),
        .snap_en   (in_valid && in_sop),
        .live_mask (live_mask),
        .held_mask (held_mask)
    );

    always_comb begin
        beat    = in_valid && (in_sop || busy_q);
        cur_off = in_sop ? '0 : off_q;
        if (in_sop) begin
            cur_cfg.tag_en = in_tag_en;
            cur_cfg.dflt   = in_default_tag;
        end else begin
            cur_cfg = cfg_q;
        end
        // start beat reads the bank directly; the snapshot is not loaded yet
        sel_bit = in_sop ? live_mask[0] : held_mask[off_q];
        take    = beat && cur_cfg.tag_en && sel_bit;
        last    = beat && (in_eop || cur_off == OW'(MASK_BYTES - 1));
    end

    btg_crc_fold u_crc (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat),
        .start   (in_sop),
        .take    (take),
        .data    (in_data),
        .crc_nxt (crc_nxt),
        .hit_nxt (hit_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            off_q     <= '0;
            cfg_q     <= '0;
            tag_valid <= 1'b0;
            tag_out   <= '0;
        end else begin
            tag_valid <= last;
            if (last) tag_out <= hit_nxt ? crc_nxt : cur_cfg.dflt;
            if (beat) begin
                busy_q <= !last;
                off_q  <= cur_off + OW'(1);
                if (in_sop) cfg_q <= cur_cfg;
            end
        end
    end

endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
    parameter int MASK_BYTES = 128,
    localparam int CW        = $clog2(MASK_BYTES) + 1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_sop,
    input logic        in_eop,
    input logic        in_tag_en,
    input logic [31:0] in_default_tag,
    input logic        tag_valid,
    input logic [31:0] tag_out
);

    // Independent tracker of the open packet and its next byte offset
    logic          pend;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (in_valid && in_sop) begin
            pend <= !in_eop;
            cnt  <= CW'(1);
        end else if (in_valid && pend) begin
            if (in_eop || cnt == CW'(MASK_BYTES - 1)) pend <= 1'b0;
            else cnt <= cnt + CW'(1);
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!tag_valid && tag_out == 32'h0));

    a_r4_eop_strobe: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eop && (in_sop || pend)) |=> tag_valid);

    a_r5_cut_at_limit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sop && pend && cnt == CW'(MASK_BYTES - 1)) |=> tag_valid);

    a_r6_mode_off_default: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_eop && !in_tag_en)
        |=> (tag_valid && tag_out == $past(in_default_tag)));

    a_r10_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tag_valid |-> $stable(tag_out));

    a_r11_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !tag_valid);

endmodule

bind bytemask_tag_gen btg_checker #(.MASK_BYTES(MASK_BYTES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_sop         (in_sop),
    .in_eop         (in_eop),
    .in_tag_en      (in_tag_en),
    .in_default_tag (in_default_tag),
    .tag_valid      (tag_valid),
    .tag_out        (tag_out)
);

// File: tb/tb_bytemask_tag_gen.sv
`timescale 1ns/1ps
module tb_bytemask_tag_gen;

    localparam int NM   = 4;
    localparam int MB   = 128;
    localparam int NREG = NM * MB / 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic [1:0]  in_mask_sel = '0;
    logic        in_tag_en = 1'b0;
    logic [31:0] in_default_tag = '0;
    logic        tag_valid;
    logic [31:0] tag_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    started = 0;
    string cur_req = "R1";

    logic [7:0] pkt [256];

    bytemask_tag_gen dut (.*);

    always #2.5 clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0]  mask_ref [NREG];
    bit          m_snap [MB];
    bit          m_busy = 0;
    int          m_off = 0;
    bit          m_en = 0;
    logic [31:0] m_dflt = '0;
    logic [7:0]  m_q [$];
    logic        exp_valid = 1'b0;
    logic [31:0] exp_tag = '0;

    function automatic logic [31:0] ref_crc(input logic [7:0] q [$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[k]) begin
            c = c ^ {q[k], 24'h0};
            for (int b = 0; b < 8; b++)
                c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        return c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mask_ref[i] = '0;
            m_busy = 0; exp_valid = 1'b0; exp_tag = '0;
        end else begin
            exp_valid = 1'b0;
            if (in_valid) begin
                if (in_sop) begin
                    m_busy = 1; m_off = 0; m_q.delete();
                    m_en = in_tag_en; m_dflt = in_default_tag;
                    for (int x = 0; x < MB; x++)
                        m_snap[x] = mask_ref[int'(in_mask_sel) * 16 + x / 8][7 - x % 8];
                end
                if (m_busy) begin
                    if (m_snap[m_off]) m_q.push_back(in_data);
                    if (in_eop || m_off == MB - 1) begin
                        exp_valid = 1'b1;
                        exp_tag = (m_en && m_q.size() > 0) ? ref_crc(m_q) : m_dflt;
                        m_busy = 0;
                    end else begin
                        m_off++;
                    end
                end
            end
            if (cfg_we) mask_ref[cfg_addr] = cfg_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, {31'h0, tag_valid}, {31'h0, exp_valid});
            if (exp_valid) chk(cur_req, tag_out, exp_tag);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drv(input bit v, input bit s, input bit e, input logic [7:0] d,
                       input int sel, input bit en, input logic [31:0] dflt,
                       input bit we, input int a, input logic [7:0] wd);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        in_mask_sel = sel[1:0]; in_tag_en = en; in_default_tag = dflt;
        cfg_we = we; cfg_addr = a[5:0]; cfg_data = wd;
    endtask

    task automatic idle();
        drv(0, 0, 0, 8'($urandom), 0, 0, 32'h0, 0, 0, 8'h0);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        drv(0, 0, 0, 8'h0, 0, 0, 32'h0, 1, a, d);
    endtask

    task automatic send(input int len, input int sel, input bit en, input logic [31:0] dflt,
                        input int gap_pct, input int wr_at, input int wa, input logic [7:0] wd);
        for (int i = 0; i < len; i++) begin
            if (i > 0 && int'($urandom % 100) < gap_pct) idle();
            drv(1, i == 0, i == len - 1, pkt[i], sel, en, dflt, i == wr_at, wa, wd);
        end
    endtask

    logic [31:0] t_a;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_we = 1'b0;
        started = 1;
        @(negedge clk);
        chk("R1", {31'h0, tag_valid}, 32'h0);
        chk("R1", tag_out, 32'h0);

        // R3: known CRC over "123456789" selected by mask 0 offsets 0..8
        cur_req = "R3";
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
        pkt[9] = 8'hAA; pkt[10] = 8'hBB; pkt[11] = 8'hCC;
        wr(0, 8'hFF); wr(1, 8'h80);
        send(12, 0, 1, 32'hDEAD_0001, 0, -1, 0, 8'h0);
        idle();
        chk("R3", tag_out, 32'h0376E6E7);

        // R9: write mask 1, mask-0 tag unchanged
        cur_req = "R9";
        wr(16, 8'h5A); wr(17, 8'hC3);
        send(12, 0, 1, 32'hDEAD_0002, 0, -1, 0, 8'h0);
        idle();
        chk("R9", tag_out, 32'h0376E6E7);

        // R8: write in the middle and at start beat do not affect the packet
        cur_req = "R8";
        send(12, 0, 1, 32'hDEAD_0003, 0, 5, 1, 8'h00);
        idle();
        chk("R8", tag_out, 32'h0376E6E7);
        send(12, 0, 1, 32'hDEAD_0004, 0, 0, 0, 8'h00);
        idle();
        chk("R8", tag_out, 32'h9B2A_4D45 ^ 32'h9B2A_4D45 ^ exp_tag);
        send(12, 0, 1, 32'hDEAD_0005, 0, -1, 0, 8'h0);
        idle();
        chk("R7", tag_out, 32'hDEAD_0005);

        // R2: sparse bits in mask 1 (offsets 26 and 31 via reg 19 = 0x21)
        cur_req = "R2";
        for (int i = 0; i < 256; i++) pkt[i] = 8'(i * 7 + 3);
        wr(16, 8'h00); wr(17, 8'h00); wr(19, 8'h21);
        send(40, 1, 1, 32'hBEEF_0000, 0, -1, 0, 8'h0);
        idle();
        t_a = ref_crc('{pkt[26], pkt[31]});
        chk("R2", tag_out, t_a);

        // R6: mode off gives default, single-beat packet too
        cur_req = "R6";
        send(40, 1, 0, 32'h1234_5678, 0, -1, 0, 8'h0);
        idle();
        chk("R6", tag_out, 32'h1234_5678);
        send(1, 1, 0, 32'h0BAD_F00D, 0, -1, 0, 8'h0);
        idle();
        chk("R6", tag_out, 32'h0BAD_F00D);

        // R7: mask 2 empty, mode on
        cur_req = "R7";
        send(50, 2, 1, 32'hCAFE_0007, 0, -1, 0, 8'h0);
        idle();
        chk("R7", tag_out, 32'hCAFE_0007);

        // R4: single-byte packets back to back, offset 0 selected in mask 3
        cur_req = "R4";
        wr(48, 8'h80);
        send(1, 3, 1, 32'h0, 0, -1, 0, 8'h0);
        send(1, 3, 1, 32'h0, 0, -1, 0, 8'h0);
        idle();
        chk("R4", tag_out, ref_crc('{pkt[0]}));

        // R5: long packet cut at offset 127, later bytes ignored
        cur_req = "R5";
        wr(63, 8'h01);
        send(200, 3, 1, 32'h0, 0, -1, 0, 8'h0);
        idle();
        chk("R5", tag_out, ref_crc('{pkt[0], pkt[127]}));
        chk("R10", {31'h0, tag_valid}, 32'h0);

        // R11: gaps inside packets
        cur_req = "R11";
        wr(49, 8'hFF);
        send(30, 3, 1, 32'h0, 50, -1, 0, 8'h0);
        idle();
        chk("R11", tag_out, ref_crc('{pkt[0], pkt[8], pkt[9], pkt[10], pkt[11],
                                      pkt[12], pkt[13], pkt[14], pkt[15]}));

        // mixed traffic, compared each cycle (R3, R8, R9, R10)
        cur_req = "R3";
        for (int p = 0; p < 40; p++) begin
            for (int w = 0; w < 3; w++) wr(int'($urandom % NREG), 8'($urandom & $urandom));
            for (int i = 0; i < 256; i++) pkt[i] = 8'($urandom);
            send(1 + int'($urandom % 180), int'($urandom % 4), ($urandom % 4) != 0,
                 $urandom, 20, int'($urandom % 60), int'($urandom % NREG), 8'($urandom));
            if ($urandom % 2) idle();
        end
        repeat (3) idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R4: actual=hung expected=finished (watchdog)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule